// File: doc/BRIEF.md
# Debug Abstract Command Engine

This block runs abstract debug commands that a debugger issues over a 32-bit register bus. The debugger puts arguments into the data words and then writes the command word. The engine checks the command. It then reads or writes one general-purpose register of a halted hart through a simple register-file port. After that it can start the program buffer in the core and wait until the program buffer reports completion. A status word shows a busy flag and an error code. The debugger polls the busy flag, or it sends a whole burst of commands and reads the error code once at the end.

The error code is sticky. Any misuse sets it: a write while busy, an unsupported command, a hart that is not halted, or a program-buffer fault. Once set, it blocks new commands until software clears it. Each data word has an auto-execute enable. When a data word with its enable set is read or written over the bus, the last command runs again. A stream of values can therefore be moved with one bus access per value.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset the status word (address 0x16) reads busy (bit 12) = 0, error (bits 10:8) = 0, program-buffer size in bits 28:24 and data-word count in bits 3:0 (0x08000002 with the default sizes). The data words (0x04, 0x05) read 0.
- R2: A command write (address 0x17) with error 0 starts the command. When the command needs a transfer or a program-buffer run, busy reads 1 in the next cycle, and it returns to 0 when the command ends.
- R3: A transfer with the write bit set (bit 17 transfer, bit 16 write) and access size 2 (bits 22:20) copies data word 0 into GPR number regno-0x1000. The register number is bits 15:0 and must lie in 0x1000..0x101F.
- R4: A transfer with the write bit clear loads that GPR into data word 0 before busy returns to 0.
- R5: A type field (bits 31:24) other than 0, or a transfer with size not 2 or a regno outside the GPR range, sets error 2. No hart access takes place.
- R6: When a transfer or program-buffer run is requested (bit 17 or bit 18) and the hart is not halted, error 4 is set. No hart access and no program-buffer start take place.
- R7: With the post-execute bit (bit 18) set, the engine raises pb_start for one cycle after any transfer and stays busy until pb_done. A pb_fault with pb_done sets error 3.
- R8: A bus write to the command word, a data word or a program-buffer word (0x20 + i) while busy sets error 1, if the error was 0, and is ignored. A data-word read while busy also sets error 1.
- R9: The error field is sticky and is cleared only by writing 1s to its bits of the status word, one bit for each 1. While it is nonzero, a command write or auto-execute access does not run.
- R10: Bit i of the auto-execute word (0x18) makes any bus read or write of data word i, while idle with error 0, run the last command again after the write has taken effect. Data words with their bit clear do not trigger.
- R11: Program-buffer words written over the bus read back on the bus and on pb_rword for the index on pb_ridx.
- R12: Each hart access lasts exactly one cycle, and read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hart_halted | input | 1 | Target hart is halted |
| gpr_re | output | 1 | GPR read strobe |
| gpr_we | output | 1 | GPR write strobe |
| gpr_idx | output | 5 | GPR number |
| gpr_wdata | output | 32 | GPR write data |
| gpr_rdata | input | 32 | GPR read data, valid in the strobe cycle |
| pb_start | output | 1 | One-cycle request to run the program buffer |
| pb_done | input | 1 | Program buffer finished |
| pb_fault | input | 1 | Program buffer finished with a fault (with pb_done) |
| pb_ridx | input | 3 | Program-buffer word index requested by the core |
| pb_rword | output | 32 | Program-buffer word at pb_ridx |

## Verification
The hardest case to reach is a burst collision. A bus access arrives during the single busy cycle of a transfer that auto-execute started. The error must then be set and the second value dropped, while the first value still lands in the hart. The bench reaches it with two data-word writes on consecutive clock cycles. For the program-buffer path, a bench model holds pb_done back for several cycles. This keeps the engine busy long enough to land writes to the data and program-buffer words inside the window. The error must then persist across a refused command and a partial clear.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_NOTSUP = 3'd2,
        ERR_EXCEPT = 3'd3,
        ERR_HALT   = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_PBGO   = 2'd2,
        ST_PBWAIT = 2'd3
    } st_e;

    // command word field positions
    localparam int CMD_TYPE_LO = 24;
    localparam int CMD_SIZE_LO = 20;
    localparam int CMD_POST    = 18;
    localparam int CMD_XFER    = 17;
    localparam int CMD_WRITE   = 16;
    localparam logic [2:0]  SIZE_WORD = 3'd2;
    localparam logic [10:0] GPR_PAGE  = 11'h080; // regno 0x1000..0x101F

    typedef struct packed {
        err_e       err;
        logic       xfer;
        logic       wr;
        logic       post;
        logic [4:0] idx;
    } dec_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_pkg::*;
(
    input  logic [31:0] cmd,
    input  logic        halted,
    output dec_t        dec
);
    logic unused_bits;
    assign unused_bits = ^{cmd[23], cmd[19]};

    always_comb begin
        dec.xfer = cmd[CMD_XFER];
        dec.wr   = cmd[CMD_WRITE];
        dec.post = cmd[CMD_POST];
        dec.idx  = cmd[4:0];
        dec.err  = ERR_NONE;
        if (cmd[31:CMD_TYPE_LO] != 8'h00) begin
            dec.err = ERR_NOTSUP;
        end else if ((cmd[CMD_XFER] || cmd[CMD_POST]) && !halted) begin
            dec.err = ERR_HALT;
        end else if (cmd[CMD_XFER] &&
                     ((cmd[CMD_SIZE_LO+2:CMD_SIZE_LO] != SIZE_WORD) ||
                      (cmd[15:5] != GPR_PAGE))) begin
            dec.err = ERR_NOTSUP;
        end
    end
endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank #(
    parameter int NDATA = 2,
    parameter int NPB   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NDATA-1:0]       dat_we,
    input  logic [NPB-1:0]         pb_we,
    input  logic [31:0]            wdata,
    input  logic                   cap_we,
    input  logic [31:0]            cap_data,
    output logic [NDATA-1:0][31:0] dat_o,
    output logic [NPB-1:0][31:0]   pb_o
);
    logic [NDATA-1:0][31:0] dat_d, dat_q;
    logic [NPB-1:0][31:0]   pb_d,  pb_q;

    // data words: bus writes, word 0 also takes the hart read result
    generate
        for (genvar gi = 0; gi < NDATA; gi++) begin : g_dat
            always_comb begin
                dat_d[gi] = dat_q[gi];
                if (dat_we[gi]) begin
                    dat_d[gi] = wdata;
                end
                if (gi == 0 && cap_we) begin
                    dat_d[gi] = cap_data;
                end
            end
        end
        for (genvar gp = 0; gp < NPB; gp++) begin : g_pb
            always_comb begin
                pb_d[gp] = pb_q[gp];
                if (pb_we[gp]) begin
                    pb_d[gp] = wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            pb_q  <= '0;
        end else begin
            dat_q <= dat_d;
            pb_q  <= pb_d;
        end
    end

    assign dat_o = dat_q;
    assign pb_o  = pb_q;
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbg_pkg::*;
#(
    parameter int NDATA  = 2,
    parameter int NPB    = 8,
    parameter int ADDR_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic                   hart_halted,
    output logic                   gpr_re,
    output logic                   gpr_we,
    output logic [4:0]             gpr_idx,
    output logic [31:0]            gpr_wdata,
    input  logic [31:0]            gpr_rdata,
    output logic                   pb_start,
    input  logic                   pb_done,
    input  logic                   pb_fault,
    input  logic [$clog2(NPB)-1:0] pb_ridx,
    output logic [31:0]            pb_rword
);
    localparam int PBI_W = $clog2(NPB);
    localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(7'h04);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(7'h16);
    localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(7'h17);
    localparam logic [ADDR_W-1:0] AEX_ADDR  = ADDR_W'(7'h18);
    localparam logic [ADDR_W-1:0] PB_BASE   = ADDR_W'(7'h20);
    localparam logic [4:0] NPB_F   = 5'(NPB);
    localparam logic [3:0] NDATA_F = 4'(NDATA);

    typedef struct packed {
        st_e              st;
        logic [31:0]      cmd;
        err_e             err;
        logic [NDATA-1:0] aex;
    } state_t;

    state_t s_d, s_q;

    logic [NDATA-1:0]       dat_sel, dat_hit, dat_we;
    logic [NPB-1:0]         pb_sel, pb_hit, pb_we;
    logic [NDATA-1:0][31:0] dat_words;
    logic [NPB-1:0][31:0]   pb_words;
    logic                   ctrl_wr, cmd_wr, aex_wr, busy, start, busy_viol, cap_we;
    logic [31:0]            cmd_sel;
    dec_t                   dec;

    // address decode
    generate
        for (genvar gi = 0; gi < NDATA; gi++) begin : g_dsel
            assign dat_sel[gi] = (bus_addr == DATA_BASE + ADDR_W'(gi));
        end
        for (genvar gp = 0; gp < NPB; gp++) begin : g_psel
            assign pb_sel[gp] = (bus_addr == PB_BASE + ADDR_W'(gp));
        end
    endgenerate

    assign dat_hit = dat_sel & {NDATA{bus_valid}};
    assign pb_hit  = pb_sel & {NPB{bus_valid && bus_write}};
    assign ctrl_wr = bus_valid && bus_write && (bus_addr == CTRL_ADDR);
    assign cmd_wr  = bus_valid && bus_write && (bus_addr == CMD_ADDR);
    assign aex_wr  = bus_valid && bus_write && (bus_addr == AEX_ADDR);
    assign busy    = (s_q.st != ST_IDLE);

    // the command word to check: the incoming one on a command write, else the held one
    assign cmd_sel = (cmd_wr && !busy) ? bus_wdata : s_q.cmd;

    dbg_cmd_decode u_dec (
        .cmd    (cmd_sel),
        .halted (hart_halted),
        .dec    (dec)
    );

    dbg_regbank #(.NDATA(NDATA), .NPB(NPB)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_we   (dat_we),
        .pb_we    (pb_we),
        .wdata    (bus_wdata),
        .cap_we   (cap_we),
        .cap_data (gpr_rdata),
        .dat_o    (dat_words),
        .pb_o     (pb_words)
    );

    always_comb begin
        s_d       = s_q;
        start     = 1'b0;
        busy_viol = 1'b0;
        dat_we    = '0;
        pb_we     = '0;
        cap_we    = 1'b0;
        gpr_re    = 1'b0;
        gpr_we    = 1'b0;
        pb_start  = 1'b0;

        if (ctrl_wr) begin
            s_d.err = err_e'(s_q.err & ~bus_wdata[10:8]);
        end
        if (aex_wr) begin
            s_d.aex = bus_wdata[NDATA-1:0];
        end

        if (busy) begin
            busy_viol = (|dat_hit) || (|pb_hit) || cmd_wr;
        end else begin
            dat_we = dat_hit & {NDATA{bus_write}};
            pb_we  = pb_hit;
            if (cmd_wr) begin
                s_d.cmd = bus_wdata;
            end
            start = (cmd_wr || (|(dat_hit & s_q.aex))) && (s_q.err == ERR_NONE);
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec.err != ERR_NONE) begin
                        s_d.err = dec.err;
                    end else if (dec.xfer) begin
                        s_d.st = ST_XFER;
                    end else if (dec.post) begin
                        s_d.st = ST_PBGO;
                    end
                end
            end
            ST_XFER: begin
                gpr_we = dec.wr;
                gpr_re = !dec.wr;
                cap_we = !dec.wr;
                s_d.st = dec.post ? ST_PBGO : ST_IDLE;
            end
            ST_PBGO: begin
                pb_start = 1'b1;
                s_d.st   = ST_PBWAIT;
            end
            ST_PBWAIT: begin
                if (pb_done) begin
                    s_d.st = ST_IDLE;
                    if (pb_fault && s_q.err == ERR_NONE) begin
                        s_d.err = ERR_EXCEPT;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (busy_viol && s_q.err == ERR_NONE) begin
            s_d.err = ERR_BUSY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cmd: '0, err: ERR_NONE, aex: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign gpr_idx   = dec.idx;
    assign gpr_wdata = dat_words[0];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[28:24] = NPB_F;
            bus_rdata[12]    = busy;
            bus_rdata[10:8]  = s_q.err;
            bus_rdata[3:0]   = NDATA_F;
        end else if (bus_addr == CMD_ADDR) begin
            bus_rdata = s_q.cmd;
        end else if (bus_addr == AEX_ADDR) begin
            bus_rdata[NDATA-1:0] = s_q.aex;
        end else begin
            for (int i = 0; i < NDATA; i++) begin
                if (dat_sel[i]) bus_rdata = dat_words[i];
            end
            for (int i = 0; i < NPB; i++) begin
                if (pb_sel[i]) bus_rdata = pb_words[i];
            end
        end
    end

    always_comb begin
        pb_rword = '0;
        for (int i = 0; i < NPB; i++) begin
            if (pb_ridx == PBI_W'(i)) pb_rword = pb_words[i];
        end
    end

    // views for the bound checker
    logic [2:0]  chk_err;
    logic [31:0] chk_cmd;
    logic        chk_busy;
    assign chk_err  = s_q.err;
    assign chk_cmd  = s_q.cmd;
    assign chk_busy = busy;

endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              gpr_re,
    input logic              gpr_we,
    input logic              pb_start,
    input logic [2:0]        chk_err,
    input logic [31:0]       chk_cmd,
    input logic              chk_busy
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(7'h16);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(7'h17);

    p_exclusive_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_re && gpr_we));

    p_single_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (gpr_re || gpr_we) |=> !(gpr_re || gpr_we));

    p_pb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pb_start |=> !pb_start);

    p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_err != 3'd0 && !(bus_valid && bus_write && bus_addr == CTRL_A))
        |=> chk_err == $past(chk_err));

    p_busy_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_busy && bus_valid && bus_write && bus_addr == CMD_A)
        |=> chk_cmd == $past(chk_cmd));

    p_busy_cmd_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_busy && bus_valid && bus_write && bus_addr == CMD_A)
        |=> chk_err != 3'd0);
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .gpr_re    (gpr_re),
    .gpr_we    (gpr_we),
    .pb_start  (pb_start),
    .chk_err   (chk_err),
    .chk_cmd   (chk_cmd),
    .chk_busy  (chk_busy)
);

// File: tb/dbg_cmd_engine_bench.sv
`timescale 1ns/1ps
module dbg_cmd_engine_bench;
    localparam logic [6:0] A_D0 = 7'h04, A_D1 = 7'h05, A_CTRL = 7'h16,
                           A_CMD = 7'h17, A_AEX = 7'h18, A_PB = 7'h20;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        hart_halted = 1'b1;
    logic        gpr_re, gpr_we, pb_start, pb_done, pb_fault;
    logic [4:0]  gpr_idx;
    logic [31:0] gpr_wdata, gpr_rdata, pb_rword;
    logic [2:0]  pb_ridx = '0;

    int n_chk = 0, n_fail = 0;
    int pb_delay = 3;
    logic pb_fault_sel = 1'b0;

    always #2 clk = ~clk;

    dbg_cmd_engine u_dbg_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hart_halted(hart_halted), .gpr_re(gpr_re), .gpr_we(gpr_we),
        .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata), .gpr_rdata(gpr_rdata),
        .pb_start(pb_start), .pb_done(pb_done), .pb_fault(pb_fault),
        .pb_ridx(pb_ridx), .pb_rword(pb_rword)
    );

    // hart register file model
    logic [31:0] hregs [32];
    int acc_cnt, pb_starts, pb_cnt;
    assign gpr_rdata = hregs[gpr_idx];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) hregs[i] <= 32'h100 + i;
            acc_cnt <= 0;
        end else begin
            if (gpr_we) hregs[gpr_idx] <= gpr_wdata;
            if (gpr_re || gpr_we) acc_cnt <= acc_cnt + 1;
        end
    end

    // program buffer model
    assign pb_done  = (pb_cnt == 1);
    assign pb_fault = pb_done && pb_fault_sel;
    always @(posedge clk) begin
        if (!rst_n) begin
            pb_cnt <= 0; pb_starts <= 0;
        end else if (pb_start) begin
            pb_cnt <= pb_delay; pb_starts <= pb_starts + 1;
        end else if (pb_cnt > 0) begin
            pb_cnt <= pb_cnt - 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic peek(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] st;
        st = 32'h1000;
        for (int i = 0; i < 100 && st[12]; i++) peek(A_CTRL, st);
        check(req, {31'd0, st[12]}, 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] arg;
        logic        halted;
        logic [2:0]  err;
        logic [31:0] data;
        logic        chk;
        logic [4:0]  idx;
        logic [31:0] val;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h00231005, 32'h12345678, 1'b1, 3'd0, 32'h12345678, 1'b1, 5'd5,  32'h12345678}, // R3
        '{32'h00221005, 32'h00000000, 1'b1, 3'd0, 32'h12345678, 1'b0, 5'd0,  32'h0},        // R4
        '{32'h0023101F, 32'hDEADBEEF, 1'b1, 3'd0, 32'hDEADBEEF, 1'b1, 5'd31, 32'hDEADBEEF}, // R3
        '{32'h0022101F, 32'h00000000, 1'b1, 3'd0, 32'hDEADBEEF, 1'b0, 5'd0,  32'h0},        // R4
        '{32'h00331007, 32'hAAAA5555, 1'b1, 3'd2, 32'hAAAA5555, 1'b1, 5'd7,  32'h107},      // R5 size
        '{32'h00220300, 32'h00000BAD, 1'b1, 3'd2, 32'h00000BAD, 1'b0, 5'd0,  32'h0},        // R5 regno
        '{32'h01221005, 32'h00000066, 1'b1, 3'd2, 32'h00000066, 1'b0, 5'd0,  32'h0},        // R5 type
        '{32'h00221005, 32'h00000055, 1'b0, 3'd4, 32'h00000055, 1'b0, 5'd0,  32'h0},        // R6
        '{32'h00201005, 32'h00000099, 1'b1, 3'd0, 32'h00000099, 1'b0, 5'd0,  32'h0},        // R2 no-op
        '{32'h00201005, 32'h0000009A, 1'b0, 3'd0, 32'h0000009A, 1'b0, 5'd0,  32'h0},        // R6 no need
        '{32'h00221000, 32'h00000000, 1'b1, 3'd0, 32'h00000100, 1'b0, 5'd0,  32'h0}         // R4 x0
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int a0, s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_CTRL, r); check("R1 status", r, 32'h08000002);
        peek(A_D0, r);   check("R1 data0", r, 32'h0);
        peek(A_D1, r);   check("R1 data1", r, 32'h0);

        // table-driven commands
        for (int v = 0; v < NV; v++) begin
            hart_halted = VECS[v].halted;
            a0 = acc_cnt;
            bus_wr(A_D0, VECS[v].arg);
            bus_wr(A_CMD, VECS[v].cmd);
            if (VECS[v].err == 3'd0 && VECS[v].cmd[17]) begin
                peek(A_CTRL, r); check("R2 busy set", {31'd0, r[12]}, 32'd1);
            end
            wait_idle("R2 busy drops");
            peek(A_CTRL, r); check("R5/R6 err code", {29'd0, r[10:8]}, {29'd0, VECS[v].err});
            peek(A_D0, r);   check("R4 data0", r, VECS[v].data);
            if (VECS[v].chk) check("R3 hart reg", hregs[VECS[v].idx], VECS[v].val);
            check("R5 R6 access count", 32'(acc_cnt - a0),
                  (VECS[v].err == 3'd0 && VECS[v].cmd[17]) ? 32'd1 : 32'd0);
            bus_wr(A_CTRL, 32'h700);
        end
        hart_halted = 1'b1;

        // R11 program buffer storage
        for (int i = 0; i < 8; i++) bus_wr(A_PB + 7'(i), 32'hC0DE0000 + i);
        peek(A_PB + 7'd3, r); check("R11 bus readback", r, 32'hC0DE0003);
        pb_ridx = 3'd5; #1;
        check("R11 core port", pb_rword, 32'hC0DE0005);

        // R7 + R8: post-execute with writes landing while busy
        pb_delay = 8; s0 = pb_starts;
        bus_wr(A_D0, 32'h4242);
        bus_wr(A_CMD, 32'h00271009);
        bus_wr(A_D0, 32'hFFFF);
        bus_wr(A_PB, 32'h0BADF00D);
        bus_wr(A_CMD, 32'h00221009);
        wait_idle("R7 busy until done");
        check("R7 one pb start", 32'(pb_starts - s0), 32'd1);
        check("R3 post write", hregs[9], 32'h4242);
        peek(A_CTRL, r); check("R8 busy error", {29'd0, r[10:8]}, 32'd1);
        peek(A_D0, r);   check("R8 data ignored", r, 32'h4242);
        peek(A_PB, r);   check("R8 progbuf ignored", r, 32'hC0DE0000);
        peek(A_CMD, r);  check("R8 cmd ignored", r, 32'h00271009);

        // R9 refused while error set, bitwise clear
        a0 = acc_cnt;
        bus_wr(A_D0, 32'h77);
        bus_wr(A_CMD, 32'h00231009);
        peek(A_CTRL, r); check("R9 refused not busy", {31'd0, r[12]}, 32'd0);
        check("R9 refused no access", 32'(acc_cnt - a0), 32'd0);
        check("R9 refused hart kept", hregs[9], 32'h4242);
        bus_wr(A_CTRL, 32'h200);
        peek(A_CTRL, r); check("R9 partial clear", {29'd0, r[10:8]}, 32'd1);
        bus_wr(A_CTRL, 32'h100);
        peek(A_CTRL, r); check("R9 cleared", {29'd0, r[10:8]}, 32'd0);

        // R7 fault
        pb_delay = 3; pb_fault_sel = 1'b1; s0 = pb_starts;
        bus_wr(A_CMD, 32'h00040000);
        wait_idle("R7 fault idle");
        peek(A_CTRL, r); check("R7 fault err", {29'd0, r[10:8]}, 32'd3);
        check("R7 start seen", 32'(pb_starts - s0), 32'd1);
        bus_wr(A_CTRL, 32'h700);
        pb_fault_sel = 1'b0;

        // R6 post-execute with running hart
        hart_halted = 1'b0; s0 = pb_starts;
        bus_wr(A_CMD, 32'h00040000);
        repeat (4) @(negedge clk);
        peek(A_CTRL, r); check("R6 post halt err", {29'd0, r[10:8]}, 32'd4);
        check("R6 no pb start", 32'(pb_starts - s0), 32'd0);
        bus_wr(A_CTRL, 32'h700);
        hart_halted = 1'b1;

        // R10 auto-execute on write
        bus_wr(A_AEX, 32'h0);
        bus_wr(A_D0, 32'h0);
        bus_wr(A_CMD, 32'h0023100A);
        wait_idle("R10 setup");
        bus_wr(A_AEX, 32'h1);
        bus_wr(A_D0, 32'h2222);
        wait_idle("R10 idle");
        check("R10 write replay", hregs[10], 32'h2222);
        a0 = acc_cnt;
        bus_wr(A_D1, 32'h5);
        repeat (3) @(negedge clk);
        check("R10 data1 no replay", 32'(acc_cnt - a0), 32'd0);

        // R10 auto-execute on read
        bus_wr(A_AEX, 32'h0);
        bus_wr(A_CMD, 32'h0022100A);
        wait_idle("R10 read setup");
        bus_wr(A_D0, 32'h0);
        bus_wr(A_AEX, 32'h1);
        bus_rd(A_D0, r);
        check("R10 pre-read value", r, 32'h0);
        wait_idle("R10 read idle");
        bus_wr(A_AEX, 32'h0);
        peek(A_D0, r); check("R10 read replay", r, 32'h2222);

        // R8 + R10 burst collision
        bus_wr(A_AEX, 32'h1);
        bus_wr(A_CMD, 32'h0023100A);
        wait_idle("R10 burst setup");
        bus_wr(A_D0, 32'hA1);
        bus_wr(A_D0, 32'hA2);
        wait_idle("R8 burst idle");
        peek(A_CTRL, r); check("R8 burst err", {29'd0, r[10:8]}, 32'd1);
        check("R10 burst first lands", hregs[10], 32'hA1);
        peek(A_D0, r); check("R8 burst second dropped", r, 32'hA1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule